// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block is the host side of a read path to a serial NOR flash. It accepts one read request at a time. A request carries a start address, a byte count, a read mode and an address length of three or four bytes. The block lowers chip select and sends the 8-bit opcode on DQ0 alone. It then sends the address on one, two or four lanes, and runs the dummy clocks with every DQ line released. Finally it collects the data phase at the lane width the mode calls for. The flash advances its address after each byte, so a single command can return any number of consecutive bytes.

Received bytes leave on a valid/ready stream. The block holds one byte in an output register. If that byte has not been taken when the next byte is about to complete, the serial clock pauses just before that byte's last rising edge, so no byte is lost. Once the requested number of bytes has arrived, chip select rises. It then stays high for a guard interval before the next request can be accepted.

The serial clock runs in SPI mode 0 and idles low. Each half period lasts `CLK_DIV` system clocks. The block latches each received group of bits at the system edge that raises the serial clock. It changes its outgoing bits only at the system edge that lowers the serial clock.

Top module: `qspi_read_seq`

## Requirements
- R1: The opcode follows the mode code on `req_mode`: 0→03h (slow read), 1→0Bh (fast), 2→3Bh (dual out), 3→BBh (dual I/O), 4→6Bh (quad out), 5→EBh (quad I/O). It is sent MSB first over 8 serial clocks on DQ0 only, with `dq_oe` = 4'b0001.
- R2: The address lane width is 1 for modes 0, 1, 2 and 4, 2 for mode 3, and 4 for mode 5. The address is sent MSB first. In each clock the higher-numbered DQ line carries the more significant bit, and `dq_oe` enables exactly the lanes in use.
- R3: The address is A[23:0] (24 bits) when `req_addr4b` is 0, and A[31:0] (32 bits) when it is 1.
- R4: After the address, every mode except mode 0 runs `DUMMY_CYCLES` serial clocks. Mode 0 runs none. `dq_oe` is 0 during the dummy and data phases.
- R5: Data is read on DQ1 alone for modes 0 and 1, on DQ[1:0] for modes 2 and 3, and on DQ[3:0] for modes 4 and 5. Bytes are assembled MSB first, which takes 8, 4 or 2 serial clocks per byte.
- R6: A request delivers exactly `req_len`+1 bytes, from consecutive addresses. Chip select rises after the last byte's final serial clock, and no further byte appears.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` stay unchanged. A slow consumer pauses the serial clock instead of losing data.
- R8: `sclk` is low whenever `cs_n` is high. Each level of `sclk` lasts at least `CLK_DIV` system clocks.
- R9: `cs_n` stays high for at least `CS_GAP` system clocks between commands. `req_ready` is high only when `cs_n` is high and the block is idle.
- R10: Mode codes 6 and 7 behave exactly like mode 1 (fast read).
- R11: After reset, `cs_n` is 1, `sclk` is 0, `dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Number of bytes minus one |
| req_mode | input | 3 | Read mode code (see R1, R10) |
| req_addr4b | input | 1 | 1 selects a 4-byte address |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Received byte |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| dq_out | output | 4 | Values driven onto DQ[3:0] |
| dq_oe | output | 4 | Per-lane drive enable |
| dq_in | input | 4 | Values sampled from DQ[3:0] |

## Verification
The hardest case to reach from the ports is the pause at a byte boundary. The output register must still be full at the exact rising edge that would complete the next byte, and only short bursts on four lanes make that timing tight. The bench withholds `rd_ready` on two cycles out of three while it sweeps every mode, both address lengths and several burst lengths. A flash model in the bench changes its data only on falling serial edges. So a clock that failed to pause, or a byte that was overwritten, shows up as a wrong byte or a wrong count of serial edges.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    typedef enum logic [2:0] {
        RM_SLOW  = 3'd0,
        RM_FAST  = 3'd1,
        RM_DOUT  = 3'd2,
        RM_DIO   = 3'd3,
        RM_QOUT  = 3'd4,
        RM_QIO   = 3'd5,
        RM_RSV6  = 3'd6,
        RM_RSV7  = 3'd7
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_DATA  = 3'd4,
        PH_GAP   = 3'd5
    } phase_e;

    // lane counts are carried as the literal values 1, 2 or 4
    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] addr_lanes;
        logic [2:0] data_lanes;
        logic       has_dummy;
    } rd_profile_t;

    function automatic rd_profile_t profile_of(rd_mode_e m);
        rd_profile_t p;
        case (m)
            RM_SLOW: p = '{opcode: 8'h03, addr_lanes: 3'd1, data_lanes: 3'd1, has_dummy: 1'b0};
            RM_DOUT: p = '{opcode: 8'h3B, addr_lanes: 3'd1, data_lanes: 3'd2, has_dummy: 1'b1};
            RM_DIO:  p = '{opcode: 8'hBB, addr_lanes: 3'd2, data_lanes: 3'd2, has_dummy: 1'b1};
            RM_QOUT: p = '{opcode: 8'h6B, addr_lanes: 3'd1, data_lanes: 3'd4, has_dummy: 1'b1};
            RM_QIO:  p = '{opcode: 8'hEB, addr_lanes: 3'd4, data_lanes: 3'd4, has_dummy: 1'b1};
            default: p = '{opcode: 8'h0B, addr_lanes: 3'd1, data_lanes: 3'd1, has_dummy: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic [3:0] lane_mask(logic [2:0] lanes);
        case (lanes)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int addr_cycles(logic [2:0] lanes, logic four_byte);
        int bits;
        bits = four_byte ? 32 : 24;
        case (lanes)
            3'd1:    return bits;
            3'd2:    return bits / 2;
            default: return bits / 4;
        endcase
    endfunction

    function automatic int byte_cycles(logic [2:0] lanes);
        case (lanes)
            3'd1:    return 8;
            3'd2:    return 4;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/qrd_sclk_div.sv
module qrd_sclk_div #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qrd_tx_shift.sv
module qrd_tx_shift #(
    parameter int SR_W = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift,
    input  logic [2:0]      lanes,
    output logic [3:0]      top_bits
);
    logic [SR_W-1:0] sr;

    assign top_bits = sr[SR_W-1 -: 4];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            case (lanes)
                3'd1:    sr <= sr << 1;
                3'd2:    sr <= sr << 2;
                default: sr <= sr << 4;
            endcase
        end
    end
endmodule

// File: rtl/qrd_rx_pack.sv
module qrd_rx_pack (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample,
    input  logic [2:0] lanes,
    input  logic [3:0] dq_in,
    output logic [7:0] next_byte
);
    logic [7:0] sr;

    always_comb begin
        case (lanes)
            3'd1:    next_byte = {sr[6:0], dq_in[1]};
            3'd2:    next_byte = {sr[5:0], dq_in[1:0]};
            default: next_byte = {sr[3:0], dq_in[3:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (sample) begin
            sr <= next_byte;
        end
    end
endmodule

// File: rtl/qspi_read_seq.sv
module qspi_read_seq
    import qrd_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int DUMMY_CYCLES = 8,
    parameter int CS_GAP       = 3,
    parameter int LEN_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [2:0]       req_mode,
    input  logic             req_addr4b,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             cs_n,
    output logic             sclk,
    output logic [3:0]       dq_out,
    output logic [3:0]       dq_oe,
    input  logic [3:0]       dq_in
);
    localparam int MAX_PH = (DUMMY_CYCLES > 32) ? DUMMY_CYCLES : 32;
    localparam int CYC_W  = $clog2(MAX_PH + 1);
    localparam int GAP_W  = $clog2(CS_GAP + 2);
    localparam logic [GAP_W-1:0] GAP_LAST   = (CS_GAP > 0) ? GAP_W'(CS_GAP - 1) : '0;
    localparam logic [CYC_W-1:0] DUMMY_LAST = (DUMMY_CYCLES > 0) ? CYC_W'(DUMMY_CYCLES - 1) : '0;
    localparam logic [CYC_W-1:0] CMD_LAST   = CYC_W'(7);
    localparam bit DUMMY_EN = (DUMMY_CYCLES > 0);

    phase_e            ph;
    rd_profile_t       prof;
    logic              a4_q;
    logic [CYC_W-1:0]  cyc;
    logic [LEN_W-1:0]  left;
    logic [GAP_W-1:0]  gcnt;
    logic              sclk_q;
    logic              cs_q;
    logic              rv_q;
    logic [7:0]        rd_q;

    logic              run, tick, toggle, rise, fall, stall, completing, accept;
    logic [CYC_W-1:0]  addr_last, byte_last;
    logic [3:0]        tx_top;
    logic [7:0]        rx_byte;
    logic [2:0]        tx_lanes;
    logic [39:0]       tx_init;
    rd_profile_t       req_prof;

    assign req_prof   = profile_of(rd_mode_e'(req_mode));
    assign req_ready  = (ph == PH_IDLE);
    assign accept     = req_valid && (ph == PH_IDLE);
    assign run        = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_DUMMY) || (ph == PH_DATA);
    assign addr_last  = CYC_W'(addr_cycles(prof.addr_lanes, a4_q) - 1);
    assign byte_last  = CYC_W'(byte_cycles(prof.data_lanes) - 1);
    assign completing = (ph == PH_DATA) && !sclk_q && (cyc == byte_last);
    assign stall      = completing && rv_q && !rd_ready;
    assign toggle     = tick && !stall;
    assign rise       = toggle && !sclk_q;
    assign fall       = toggle && sclk_q;
    assign tx_lanes   = (ph == PH_CMD) ? 3'd1 : prof.addr_lanes;
    assign tx_init    = req_addr4b ? {req_prof.opcode, req_addr}
                                   : {req_prof.opcode, req_addr[23:0], 8'h00};

    qrd_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    qrd_tx_shift #(.SR_W(40)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(tx_init),
        .shift   (fall && ((ph == PH_CMD) || (ph == PH_ADDR))),
        .lanes   (tx_lanes),
        .top_bits(tx_top)
    );

    qrd_rx_pack u_rx (
        .clk      (clk),
        .rst      (rst),
        .sample   (rise && (ph == PH_DATA)),
        .lanes    (prof.data_lanes),
        .dq_in    (dq_in),
        .next_byte(rx_byte)
    );

    always_comb begin
        dq_out = 4'b0000;
        dq_oe  = 4'b0000;
        case (ph)
            PH_CMD: begin
                dq_out = {3'b000, tx_top[3]};
                dq_oe  = 4'b0001;
            end
            PH_ADDR: begin
                dq_oe = lane_mask(prof.addr_lanes);
                case (prof.addr_lanes)
                    3'd1:    dq_out = {3'b000, tx_top[3]};
                    3'd2:    dq_out = {2'b00, tx_top[3:2]};
                    default: dq_out = tx_top;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            prof   <= '0;
            a4_q   <= 1'b0;
            cyc    <= '0;
            left   <= '0;
            gcnt   <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            if (toggle) begin
                sclk_q <= ~sclk_q;
            end
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        prof <= req_prof;
                        a4_q <= req_addr4b;
                        left <= req_len;
                        cyc  <= '0;
                        cs_q <= 1'b0;
                        ph   <= PH_CMD;
                    end
                end
                PH_CMD: begin
                    if (fall) begin
                        if (cyc == CMD_LAST) begin
                            cyc <= '0;
                            ph  <= PH_ADDR;
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (fall) begin
                        if (cyc == addr_last) begin
                            cyc <= '0;
                            ph  <= (prof.has_dummy && DUMMY_EN) ? PH_DUMMY : PH_DATA;
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
                PH_DUMMY: begin
                    if (fall) begin
                        if (cyc == DUMMY_LAST) begin
                            cyc <= '0;
                            ph  <= PH_DATA;
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (fall) begin
                        if (cyc == byte_last) begin
                            cyc <= '0;
                            if (left == '0) begin
                                cs_q <= 1'b1;
                                gcnt <= '0;
                                ph   <= PH_GAP;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (gcnt == GAP_LAST) begin
                        ph <= PH_IDLE;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // output byte register: drained by rd_ready, refilled at a byte-completing rise
    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q <= 1'b0;
            rd_q <= '0;
        end else begin
            if (rv_q && rd_ready) begin
                rv_q <= 1'b0;
            end
            if (rise && completing) begin
                rv_q <= 1'b1;
                rd_q <= rx_byte;
            end
        end
    end

    assign rd_valid = rv_q;
    assign rd_data  = rd_q;
    assign cs_n     = cs_q;
    assign sclk     = sclk_q;

endmodule

// File: rtl/qrd_checker.sv
module qrd_checker #(
    parameter int CS_GAP = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] dq_out,
    input logic [3:0] dq_oe,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);
    localparam int HW = $clog2(CS_GAP + 2);
    localparam logic [HW-1:0] HSAT = HW'(CS_GAP);

    logic [HW-1:0] hi_cnt;
    logic          cs_prev;
    logic          cs_fall;

    assign cs_fall = cs_prev && !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= HSAT;
            cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_n;
            if (!cs_n) begin
                hi_cnt <= '0;
            end else if (hi_cnt != HSAT) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_oe_released_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dq_oe == 4'b0000));

    p_oe_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0001) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

    p_out_hold_hi_r2: assert property (@(posedge clk) disable iff (rst)
        sclk |=> (sclk -> $stable(dq_out)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
        cs_fall |-> (hi_cnt >= HSAT));

endmodule

bind qspi_read_seq qrd_checker #(.CS_GAP(CS_GAP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
);

// File: tb/sim_qspi_read_seq.sv
module sim_qspi_read_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 2;
    localparam int DUMMY      = 8;
    localparam int CS_GAP     = 3;
    localparam int LEN_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [2:0]       req_mode = '0;
    logic             req_addr4b = 1'b0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [7:0]       rd_data;
    logic             cs_n, sclk;
    logic [3:0]       dq_out, dq_oe;
    logic [3:0]       dq_in = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qspi_read_seq #(.CLK_DIV(CLK_DIV), .DUMMY_CYCLES(DUMMY), .CS_GAP(CS_GAP), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode), .req_addr4b(req_addr4b),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cs_n(cs_n), .sclk(sclk), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected behaviour derived from the requirements
    function automatic logic [7:0] exp_op(int m);
        case (m)
            0: return 8'h03; 2: return 8'h3B; 3: return 8'hBB;
            4: return 8'h6B; 5: return 8'hEB; default: return 8'h0B;
        endcase
    endfunction
    function automatic int exp_al(int m);
        return (m == 3) ? 2 : (m == 5) ? 4 : 1;
    endfunction
    function automatic int exp_dl(int m);
        return (m == 2 || m == 3) ? 2 : (m == 4 || m == 5) ? 4 : 1;
    endfunction
    function automatic int exp_dum(int m);
        return (m == 0) ? 0 : DUMMY;
    endfunction
    function automatic logic [7:0] mem_byte(logic [31:0] a);
        logic [7:0] v;
        v = (a[7:0] * 8'd13) ^ a[15:8];
        return v + a[23:16] + a[31:24];
    endfunction

    // flash model
    int          f_mode = 1;
    bit          f_a4 = 0;
    int          cs_falls = 0;
    int          seen_falls = 0;
    int          rc = 0;
    logic [7:0]  f_op = '0;
    logic [31:0] f_addr = '0;
    int          f_oe_bad = 0;

    always @(negedge cs_n) cs_falls++;

    always @(posedge sclk) begin
        int al, ac;
        if (!cs_n) begin
            if (seen_falls != cs_falls) begin
                seen_falls = cs_falls;
                rc = 0; f_op = '0; f_addr = '0;
            end
            al = exp_al(f_mode);
            ac = (f_a4 ? 32 : 24) / al;
            if (rc < 8) begin
                f_op = {f_op[6:0], dq_out[0]};
                if (dq_oe !== 4'b0001) f_oe_bad++;
            end else if (rc < 8 + ac) begin
                case (al)
                    1: f_addr = {f_addr[30:0], dq_out[0]};
                    2: f_addr = {f_addr[29:0], dq_out[1:0]};
                    default: f_addr = {f_addr[27:0], dq_out[3:0]};
                endcase
                if (dq_oe !== ((al == 1) ? 4'b0001 : (al == 2) ? 4'b0011 : 4'b1111)) f_oe_bad++;
            end else if (dq_oe !== 4'b0000) begin
                f_oe_bad++;
            end
            rc++;
        end
    end

    always @(negedge sclk) begin
        int base, dl, per, g, sh;
        logic [7:0] b;
        logic [3:0] v;
        if (!cs_n && seen_falls == cs_falls) begin
            base = 8 + (f_a4 ? 32 : 24) / exp_al(f_mode) + exp_dum(f_mode);
            if (rc >= base) begin
                dl  = exp_dl(f_mode);
                per = 8 / dl;
                g   = rc - base;
                b   = mem_byte(f_addr + 32'(g / per));
                sh  = 8 - dl * ((g % per) + 1);
                v   = 4'((b >> sh) & 8'((1 << dl) - 1));
                case (dl)
                    1: dq_in = {~v[0], v[0], v[0], ~v[0]};
                    2: dq_in = {~v[1:0], v[1:0]};
                    default: dq_in = v;
                endcase
            end
        end
    end

    // port monitors
    int bad_hp = 0, bad_idle = 0, bad_gap = 0, bad_ready = 0;
    int hp = 0, hi = 100;
    logic sclk_prev = 1'b0, cs_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (sclk !== sclk_prev) begin
                if (hp < CLK_DIV) bad_hp++;
                hp = 1;
            end else hp++;
            if (cs_n && sclk) bad_idle++;
            if (req_ready && !cs_n) bad_ready++;
            if (cs_prev && !cs_n && hi < CS_GAP) bad_gap++;
            hi = cs_n ? hi + 1 : 0;
            sclk_prev = sclk;
            cs_prev = cs_n;
        end
    end

    task automatic run_txn(input logic [31:0] addr, input int len, input int mode,
                           input bit a4, input bit stall);
        int got, t, per, ac, exp_edges, oe0;
        logic [31:0] ea;
        ea  = a4 ? addr : {8'h00, addr[23:0]};
        per = 8 / exp_dl(mode);
        ac  = (a4 ? 32 : 24) / exp_al(mode);
        exp_edges = 8 + ac + exp_dum(mode) + (len + 1) * per;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        f_mode = mode; f_a4 = a4; oe0 = f_oe_bad;
        req_addr = addr; req_len = LEN_W'(len); req_mode = 3'(mode); req_addr4b = a4;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "busy ready", req_ready, 0);
        got = 0; t = 0;
        while (got <= len && t < 20000) begin
            rd_ready = stall ? ((t % 3) == 2) : 1'b1;
            if (rd_valid && rd_ready) begin
                check(rd_data == mem_byte(ea + 32'(got)), (mode >= 6) ? "R10" : "R5",
                      $sformatf("byte %0d mode %0d", got, mode), rd_data, mem_byte(ea + 32'(got)));
                got++;
            end
            @(negedge clk);
            t++;
        end
        rd_ready = 1'b0;
        check(got == len + 1, "R6", "byte count", got, len + 1);
        t = 0;
        while (!(cs_n && req_ready) && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R6", "no extra byte", rd_valid, 0);
        check(f_op == exp_op(mode), (mode >= 6) ? "R10" : "R1", "opcode", f_op, exp_op(mode));
        check(f_addr == ea, "R3", $sformatf("address mode %0d a4 %0d", mode, a4), f_addr, ea);
        check(f_oe_bad == oe0, "R2", "lane enables", f_oe_bad - oe0, 0);
        check(rc == exp_edges, "R4", "serial clock count", rc, exp_edges);
    endtask

    initial begin
        int lens[3];
        lens = '{0, 2, 5};
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R11", "cs_n", cs_n, 1);
        check(sclk == 1'b0, "R11", "sclk", sclk, 0);
        check(dq_oe == 4'b0, "R11", "dq_oe", dq_oe, 0);
        check(rd_valid == 1'b0, "R11", "rd_valid", rd_valid, 0);
        check(req_ready == 1'b1, "R11", "req_ready", req_ready, 1);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 8; m++)
            for (int a = 0; a < 2; a++)
                for (int li = 0; li < 3; li++)
                    for (int s = 0; s < 2; s++)
                        run_txn(32'h00A1_2300 + 32'(m * 977 + li * 51 + s * 7) + (a ? 32'h5A00_0000 : 32'h3300_0000),
                                lens[li], m, a[0], s[0]);
        check(bad_hp == 0, "R8", "half period", bad_hp, 0);
        check(bad_idle == 0, "R8", "sclk idle", bad_idle, 0);
        check(bad_gap == 0, "R9", "cs gap", bad_gap, 0);
        check(bad_ready == 0, "R9", "ready while selected", bad_ready, 0);
        check(1'b1, "R7", "stalled sweep completed", 0, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule